// File: doc/BRIEF.md
# Two-wire command slave for a quad digital potentiometer

This block is the serial front end of a four-channel digitally controlled potentiometer. It watches an oversampled two-wire bus (clock and data), finds start and stop conditions, and accepts an 8-bit slave address. The upper nibble of that address is a fixed device type and the lower nibble must match four strapped address pins. After the address, the block takes one instruction byte. Its upper four bits are an opcode, the next two select one of four data registers, and the low two select one of four potentiometers.

Depending on the opcode, the transaction ends after the instruction byte (transfers), carries a third byte from the master (writes), returns a third byte to the master (reads), or becomes a stream of clock pulses that each move the selected wiper one step. Completed transfer and write commands are handed to the register logic as a one-cycle strobe on the closing stop condition. While the register logic reports a nonvolatile store in progress, the block does not acknowledge its address, so the master can poll for completion. The data line is open drain: the block only ever asks for it to be pulled low.

Control is one state machine with these states: IDLE, ADDR, INSTR, WDATA, ACK, TX, MACK, STEP, HOLD.
- A stop moves any state to IDLE. A start moves any state to ADDR.
- ADDR goes to ACK on a matching, non-busy address, and to IDLE otherwise.
- INSTR goes to ACK on a defined opcode and to IDLE on an undefined one. WDATA goes to ACK after 8 bits.
- ACK leaves after the ninth clock for the state picked by the byte just taken: INSTR after the address, then WDATA for writes, TX for reads, HOLD for transfers, STEP for stepping, and HOLD after a write data byte.
- TX goes to MACK after 8 bits. MACK goes to HOLD on the master's acknowledge clock.
- STEP and HOLD wait for a start or a stop.

Top module: `dpot_twowire_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) at any point restarts address reception. A stop condition (SDA rising while SCL is high) returns the block to idle.
- R2: An address byte is acknowledged only when its upper nibble is 0101 and its lower nibble equals `addr_pins`. Otherwise there is no acknowledge, and the block ignores the bus until the next start.
- R3: While `nv_busy` is high at the eighth address bit, the address is not acknowledged. With `nv_busy` low, the same address is acknowledged.
- R4: The instruction byte (bits 7:4 opcode, 3:2 register, 1:0 pot) is acknowledged only for the opcodes 1001, 1010, 1011, 1100, 1101, 1110, 0001, 1000 and 0010. Any other opcode gets no acknowledge, any bytes that follow are ignored, and no strobe results.
- R5: The transfer opcodes 1101, 1110, 0001 and 1000 need no data byte. The stop that ends such a transaction gives `cmd_valid` with `cmd_op`, `cmd_reg` and `cmd_pot` equal to the instruction fields.
- R6: The write opcodes 1010 and 1100 take a third byte, which is acknowledged. Its bits 5:0 appear on `cmd_data` and its bits 7:6 are ignored. The closing stop then gives `cmd_valid`.
- R7: The read opcodes 1001 and 1011 return a byte of two zero bits followed by `rd_data`, MSB first. `rd_data` is sampled as the instruction acknowledge ends. The data line is released on the ninth clock. Reads give no `cmd_valid`.
- R8: After opcode 0010 is acknowledged, each completed SCL pulse gives one `step_valid`. `step_up` equals the SDA level while SCL was high (1 moves up, 0 moves down). The closing stop gives no `cmd_valid`.
- R9: A start that arrives before the stop cancels any completed but unissued command, so only the command closed by a stop is issued.
- R10: After reset `sda_oe` is 0, and `sda_oe` only asserts while SCL is low.
- R11: `cmd_valid` and `step_valid` are single-cycle pulses. During `step_valid`, `cmd_op` holds 0010. During `cmd_valid`, `cmd_op` holds a transfer or write opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired value, including own drive) |
| addr_pins | input | ADDR_W | Strapped device address |
| nv_busy | input | 1 | Nonvolatile store in progress |
| rd_data | input | DATA_W | Register value for the addressed read |
| sda_oe | output | 1 | Pull the data line low when 1 |
| cmd_valid | output | 1 | One-cycle command strobe on stop |
| cmd_op | output | 4 | Opcode of the last instruction |
| cmd_reg | output | 2 | Data register select of the last instruction |
| cmd_pot | output | 2 | Pot select of the last instruction |
| cmd_data | output | DATA_W | Data from the last write byte |
| step_valid | output | 1 | One-cycle wiper step strobe |
| step_up | output | 1 | Direction of the step (1 = up) |

## Verification
Every bus event reaches the state machine two clock cycles after the pin changes: one cycle through the synchronizer and one at the edge register. Each output therefore settles within three cycles of the SCL edge that caused it. The bench holds every SCL phase for eight cycles and reads acknowledge and read-back bits halfway through the high phase, well after they have settled. The bench counts strobes on the falling system clock and compares the counts and the latched fields a full SCL phase after the stop, by which time the stop has been seen.

// File: rtl/dpot_tw_pkg.sv
package dpot_tw_pkg;

    localparam int OP_W  = 4;
    localparam int SEL_W = 2;

    localparam logic [OP_W-1:0] OP_RD_WIPER  = 4'b1001;
    localparam logic [OP_W-1:0] OP_WR_WIPER  = 4'b1010;
    localparam logic [OP_W-1:0] OP_RD_STORE  = 4'b1011;
    localparam logic [OP_W-1:0] OP_WR_STORE  = 4'b1100;
    localparam logic [OP_W-1:0] OP_RECALL    = 4'b1101;
    localparam logic [OP_W-1:0] OP_SAVE      = 4'b1110;
    localparam logic [OP_W-1:0] OP_RECALL_ALL = 4'b0001;
    localparam logic [OP_W-1:0] OP_SAVE_ALL  = 4'b1000;
    localparam logic [OP_W-1:0] OP_STEP      = 4'b0010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_INSTR, ST_WDATA, ST_ACK,
        ST_TX, ST_MACK, ST_STEP, ST_HOLD
    } tw_state_t;

    typedef enum logic [2:0] {
        CK_BAD, CK_READ, CK_WRITE, CK_XFER, CK_STEP
    } cmd_kind_t;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q    <= '1;
            sda_q    <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_q    <= {scl_q[STAGES-2:0], scl_in};
            sda_q    <= {sda_q[STAGES-2:0], sda_in};
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_lvl   = scl_q[STAGES-1];
    assign sda_lvl   = sda_q[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/tw_op_class.sv
module tw_op_class
    import dpot_tw_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output cmd_kind_t       kind
);
    always_comb begin
        case (op)
            OP_RD_WIPER, OP_RD_STORE:             kind = CK_READ;
            OP_WR_WIPER, OP_WR_STORE:             kind = CK_WRITE;
            OP_RECALL, OP_SAVE,
            OP_RECALL_ALL, OP_SAVE_ALL:           kind = CK_XFER;
            OP_STEP:                              kind = CK_STEP;
            default:                              kind = CK_BAD;
        endcase
    end
endmodule

// File: rtl/dpot_twowire_slave.sv
module dpot_twowire_slave
    import dpot_tw_pkg::*;
#(
    parameter int          ADDR_W      = 4,
    parameter int          DATA_W      = 6,
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  TYPE_ID     = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] addr_pins,
    input  logic              nv_busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              cmd_valid,
    output logic [OP_W-1:0]   cmd_op,
    output logic [SEL_W-1:0]  cmd_reg,
    output logic [SEL_W-1:0]  cmd_pot,
    output logic [DATA_W-1:0] cmd_data,
    output logic              step_valid,
    output logic              step_up
);
    localparam int BYTE_W = 8;
    localparam int TYPE_W = BYTE_W - ADDR_W;
    localparam int PAD_W  = BYTE_W - DATA_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    tw_state_t        state, state_nx, ack_next;
    logic [BYTE_W-1:0] shreg, byte_in, tx_load;
    logic [CNT_W-1:0]  bitcnt;
    logic              last_bit, addr_ok, pending, step_lvl;
    cmd_kind_t         in_kind;

    assign byte_in  = {shreg[BYTE_W-2:0], sda_lvl};
    assign tx_load  = {{PAD_W{1'b0}}, rd_data};
    assign last_bit = (bitcnt == CNT_W'(BYTE_W - 1));
    assign addr_ok  = (byte_in[BYTE_W-1 -: TYPE_W] == TYPE_ID[TYPE_W-1:0]) &&
                      (byte_in[ADDR_W-1:0] == addr_pins);

    tw_op_class u_cls (.op(byte_in[BYTE_W-1 -: OP_W]), .kind(in_kind));

    // next-state logic
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_STEP, ST_HOLD: state_nx = state;
                ST_ADDR:  if (scl_rise && last_bit)
                              state_nx = (addr_ok && !nv_busy) ? ST_ACK : ST_IDLE;
                ST_INSTR: if (scl_rise && last_bit)
                              state_nx = (in_kind != CK_BAD) ? ST_ACK : ST_IDLE;
                ST_WDATA: if (scl_rise && last_bit) state_nx = ST_ACK;
                ST_ACK:   if (scl_fall && sda_oe) state_nx = ack_next;
                ST_TX:    if (scl_fall && bitcnt == CNT_W'(BYTE_W)) state_nx = ST_MACK;
                ST_MACK:  if (scl_rise) state_nx = ST_HOLD;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_next   <= ST_IDLE;
            shreg      <= '0;
            bitcnt     <= '0;
            sda_oe     <= 1'b0;
            pending    <= 1'b0;
            step_lvl   <= 1'b0;
            cmd_valid  <= 1'b0;
            step_valid <= 1'b0;
            step_up    <= 1'b0;
            cmd_op     <= '0;
            cmd_reg    <= '0;
            cmd_pot    <= '0;
            cmd_data   <= '0;
        end else begin
            cmd_valid  <= 1'b0;
            step_valid <= 1'b0;
            if (stop_det) begin
                sda_oe    <= 1'b0;
                cmd_valid <= pending;
                pending   <= 1'b0;
            end else if (start_det) begin
                sda_oe  <= 1'b0;
                pending <= 1'b0;
                bitcnt  <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_INSTR, ST_WDATA: if (scl_rise) begin
                        shreg  <= byte_in;
                        bitcnt <= last_bit ? '0 : bitcnt + CNT_W'(1);
                        if (last_bit) begin
                            if (state == ST_ADDR) begin
                                ack_next <= ST_INSTR;
                            end else if (state == ST_WDATA) begin
                                cmd_data <= byte_in[DATA_W-1:0];
                                pending  <= 1'b1;
                                ack_next <= ST_HOLD;
                            end else begin
                                cmd_op  <= byte_in[7:4];
                                cmd_reg <= byte_in[3:2];
                                cmd_pot <= byte_in[1:0];
                                pending <= (in_kind == CK_XFER);
                                case (in_kind)
                                    CK_READ:  ack_next <= ST_TX;
                                    CK_WRITE: ack_next <= ST_WDATA;
                                    CK_STEP:  ack_next <= ST_STEP;
                                    default:  ack_next <= ST_HOLD;
                                endcase
                            end
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        if (!sda_oe) begin
                            sda_oe <= 1'b1;
                        end else if (ack_next == ST_TX) begin
                            shreg  <= tx_load;
                            sda_oe <= ~tx_load[BYTE_W-1];
                            bitcnt <= '0;
                        end else begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) bitcnt <= bitcnt + CNT_W'(1);
                        if (scl_fall) begin
                            if (bitcnt == CNT_W'(BYTE_W)) begin
                                sda_oe <= 1'b0;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_STEP: begin
                        if (scl_rise) step_lvl <= sda_lvl;
                        if (scl_fall) begin
                            step_valid <= 1'b1;
                            step_up    <= step_lvl;
                        end
                    end
                    ST_IDLE, ST_MACK, ST_HOLD: ;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dpot_tw_checker.sv
module dpot_tw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       sda_oe,
    input logic       cmd_valid,
    input logic       step_valid,
    input logic [3:0] cmd_op
);
    // R11: command strobe lasts one cycle
    a_r11_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R11: step strobe lasts one cycle
    a_r11_step_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> !step_valid);

    // R10: the data line is only pulled while the synchronized clock is low
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R5 / R6: only transfer or write opcodes are ever issued
    a_r5_strobe_op: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op inside {4'b1010, 4'b1100, 4'b1101, 4'b1110, 4'b0001, 4'b1000}));

    // R8: steps only happen under the stepping opcode
    a_r8_step_op: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> (cmd_op == 4'b0010));
endmodule

bind dpot_twowire_slave dpot_tw_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
    .cmd_valid(cmd_valid), .step_valid(step_valid), .cmd_op(cmd_op)
);

// File: tb/dpot_twowire_slave_tb.sv
module dpot_twowire_slave_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [3:0] pins = 4'b0110;
    logic       busy = 1'b0;
    logic [5:0] rdd = 6'h00;
    logic       sda_bus;
    logic       sda_oe, cmd_valid, step_valid, step_up;
    logic [3:0] cmd_op;
    logic [1:0] cmd_reg, cmd_pot;
    logic [5:0] cmd_data;

    assign sda_bus = sda_m & ~sda_oe;

    dpot_twowire_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .addr_pins(pins), .nv_busy(busy), .rd_data(rdd), .sda_oe(sda_oe),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg),
        .cmd_pot(cmd_pot), .cmd_data(cmd_data), .step_valid(step_valid),
        .step_up(step_up)
    );

    int total = 0, bad = 0, n_cmd = 0, n_up = 0, n_dn = 0;
    logic [3:0] l_op;
    logic [1:0] l_reg, l_pot;
    logic [5:0] l_dat;

    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            n_cmd = n_cmd + 1;
            l_op = cmd_op; l_reg = cmd_reg; l_pot = cmd_pot; l_dat = cmd_data;
        end
        if (rst_n && step_valid) begin
            if (step_up) n_up = n_up + 1;
            else         n_dn = n_dn + 1;
        end
    end

    localparam int H = 8;

    // {addr, instr, data, three_byte, acks(addr,instr,data), strobe}
    localparam int NV = 9;
    localparam logic [28:0] VEC [0:NV-1] = '{
        {8'h56, 8'hD6, 8'h00, 1'b0, 3'b110, 1'b1},  // R5 recall one pot
        {8'h56, 8'h8C, 8'h00, 1'b0, 3'b110, 1'b1},  // R5 save all
        {8'h56, 8'hA3, 8'h2A, 1'b1, 3'b111, 1'b1},  // R6 write wiper
        {8'h56, 8'hC9, 8'hFF, 1'b1, 3'b111, 1'b1},  // R6 pad bits ignored
        {8'h57, 8'hD0, 8'h00, 1'b0, 3'b000, 1'b0},  // R2 wrong pins
        {8'h16, 8'hD0, 8'h00, 1'b0, 3'b000, 1'b0},  // R2 wrong type nibble
        {8'h56, 8'h30, 8'h00, 1'b0, 3'b100, 1'b0},  // R4 undefined opcode
        {8'h56, 8'h1C, 8'h00, 1'b0, 3'b110, 1'b1},  // R5 recall all
        {8'h56, 8'hF4, 8'h11, 1'b1, 3'b100, 1'b0}   // R4 undefined, data ignored
    };

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string what, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; hw(H);
        scl_m = 1'b1; hw(H);
        sda_m = 1'b0; hw(H);
        scl_m = 1'b0; hw(2);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; hw(H);
        scl_m = 1'b1; hw(H);
        sda_m = 1'b1; hw(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hw(H);
            scl_m = 1'b1; hw(H);
            scl_m = 1'b0; hw(2);
        end
        sda_m = 1'b1; hw(H);
        scl_m = 1'b1; hw(H/2);
        ack = !sda_bus;
        hw(H/2);
        scl_m = 1'b0; hw(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, output logic rel);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw(H);
            scl_m = 1'b1; hw(H/2);
            b[i] = sda_bus;
            hw(H/2);
            scl_m = 1'b0; hw(2);
        end
        hw(H);
        scl_m = 1'b1; hw(H/2);
        rel = sda_bus;
        hw(H/2);
        scl_m = 1'b0; hw(2);
    endtask

    task automatic step_pulse(input logic up);
        sda_m = up; hw(H);
        scl_m = 1'b1; hw(H);
        scl_m = 1'b0; hw(2);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        logic [28:0] v;
        logic a0, a1, a2, rel;
        logic [7:0] rb;
        int c0, u0, d0;

        hw(5);
        chk("R10 reset sda_oe", sda_oe, 0);
        chk("R11 reset cmd_valid", cmd_valid, 0);
        chk("R11 reset step_valid", step_valid, 0);
        rst_n = 1'b1;
        hw(4);

        for (int k = 0; k < NV; k++) begin
            v = VEC[k];
            c0 = n_cmd;
            a2 = 1'b0;
            bus_start();
            send_byte(v[28:21], a0);
            send_byte(v[20:13], a1);
            if (v[4]) send_byte(v[12:5], a2);
            bus_stop();
            hw(4);
            chk($sformatf("R2 address ack vec %0d", k), a0, v[3]);
            chk($sformatf("R4 instruction ack vec %0d", k), a1, v[2]);
            if (v[4]) chk($sformatf("R6 data ack vec %0d", k), a2, v[1]);
            chk($sformatf("R5 R11 strobe count vec %0d", k), n_cmd - c0, v[0]);
            if (v[0]) begin
                chk($sformatf("R5 op vec %0d", k), l_op, v[20:17]);
                chk($sformatf("R5 reg vec %0d", k), l_reg, v[16:15]);
                chk($sformatf("R5 pot vec %0d", k), l_pot, v[14:13]);
                if (v[4]) chk($sformatf("R6 data vec %0d", k), l_dat, v[10:5]);
            end
            chk("R10 released after stop", sda_oe, 0);
        end

        // R7 read of a wiper register
        rdd = 6'h25; c0 = n_cmd;
        bus_start(); send_byte(8'h56, a0); send_byte(8'h91, a1);
        recv_byte(rb, rel); bus_stop(); hw(4);
        chk("R7 read ack", a1, 1);
        chk("R7 read byte", rb, 8'h25);
        chk("R7 released on ninth clock", rel, 1);
        chk("R7 no strobe on read", n_cmd - c0, 0);

        // R7 read of a data register, all ones
        rdd = 6'h3F;
        bus_start(); send_byte(8'h56, a0); send_byte(8'hBB, a1);
        recv_byte(rb, rel); bus_stop(); hw(4);
        chk("R7 read byte all ones", rb, 8'h3F);

        // R8 stepping
        c0 = n_cmd; u0 = n_up; d0 = n_dn;
        bus_start(); send_byte(8'h56, a0); send_byte(8'h22, a1);
        step_pulse(1'b1); step_pulse(1'b1); step_pulse(1'b1); step_pulse(1'b0);
        bus_stop(); hw(4);
        chk("R8 step ack", a1, 1);
        chk("R8 up steps", n_up - u0, 3);
        chk("R8 down steps", n_dn - d0, 1);
        chk("R8 no cmd strobe", n_cmd - c0, 0);

        // R3 busy store suppresses address ack
        busy = 1'b1;
        bus_start(); send_byte(8'h56, a0); bus_stop();
        chk("R3 no ack while busy", a0, 0);
        busy = 1'b0;
        bus_start(); send_byte(8'h56, a0); bus_stop();
        chk("R3 ack after busy clears", a0, 1);

        // R9 / R1: repeated start cancels the write, the next command issues
        c0 = n_cmd;
        bus_start(); send_byte(8'h56, a0); send_byte(8'hA1, a1); send_byte(8'h15, a2);
        bus_start(); send_byte(8'h56, a0); send_byte(8'hE2, a1);
        bus_stop(); hw(4);
        chk("R1 address ack after repeated start", a0, 1);
        chk("R9 only one strobe", n_cmd - c0, 1);
        chk("R9 issued op is the closed command", l_op, 4'hE);
        chk("R1 issued pot", l_pot, 2);

        summary();
    end
endmodule